// File: doc/BRIEF.md
# Boot-Block Flash Command Interface Controller

This block is the command front end and write-state sequencer of a NOR-style flash device with a boot-block layout. A host reaches it over an SRAM-like bus made of chip enable, write enable, output enable and an active-high synchronous reset. The reset also stands for leaving deep power-down. Commands are single bus writes whose low data byte is the command code. Block erase needs two bus writes: a setup code, then a confirm code that carries the block address. Word programming also needs two: a setup code, then the target address and data. While an operation runs, the host can suspend it, use the device, and resume it. This works one level deep: an erase can be suspended to make room for a word write, and that word write can itself be suspended for reads.

Reads return either array data or the status byte, depending on the current read mode. The status byte reports readiness, the two suspend states and four sticky error causes. A ready output mirrors whether an operation is actively running. Storage is a small behavioural memory. Erasing walks the block one word per cycle. Programming takes a fixed number of cycles and can only clear bits. A block map made of many small blocks at one end and large blocks elsewhere finds the erase extent. It also identifies the two boot blocks. A write-protect input locks the boot blocks, and a program-voltage-valid input locks all blocks.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array, ready is high, every status flag is clear, and memory contents are kept.
- R2: Code 20h followed by D0h erases the whole block holding the confirm-cycle address to FFFFh, one word per cycle; words of neighbouring blocks keep their contents.
- R3: Code 40h or 10h, followed by a write of address and data, programs that word after WRITE_CYCLES cycles; the new word is the old word AND the data.
- R4: Code 70h and every setup, confirm, suspend or resume command select status read mode, where a read returns the status byte in bits 7:0 with bits 15:8 zero; code FFh selects array read mode.
- R5: Status bit positions: 7 ready, 6 erase suspended, 5 erase error, 4 program error, 3 program voltage low, 2 write suspended, 1 block protected, 0 always zero; bits 5, 4, 3 and 1 are sticky until code 50h clears them.
- R6: The rdy output is low while an erase or program is running and not suspended, and high otherwise.
- R7: An erase setup followed by any code other than D0h sets status bits 5 and 4 and erases nothing.
- R8: With wp high, an erase aimed at a boot block sets bits 5 and 1, and a program aimed at one sets bits 4 and 1; neither alters the array; parameter and main blocks stay writable.
- R9: With vpp_ok low, any erase sets bits 5 and 3 and any program sets bits 4 and 3, with no change to the array.
- R10: Code B0h during an erase freezes it (bit 6 set, ready). While it is frozen, array reads and one word program are allowed. D0h resumes the erase once no program is pending.
- R11: Code B0h during a program freezes it (bit 2 set). While it is frozen, program and erase setup codes are ignored. D0h resumes the innermost suspended operation first.
- R12: Address and data of a bus write are taken from the last cycle in which chip enable and write enable were both low; values after either rises do not matter.
- R13: With BOOT_TOP=1 the top 2*SMALL_W words are the boot blocks, the 6*SMALL_W words below them are parameter blocks of SMALL_W words, and the rest are main blocks of BIG_W words; BOOT_TOP=0 mirrors this at address 0.
- R14: While an operation runs unsuspended, any code except B0h is ignored, and reads return the status byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (deep power-down exit) |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW (9) | Word address |
| wdata | input | DW (16) | Write data; command code in bits 7:0 |
| wp | input | 1 | High locks the boot blocks |
| vpp_ok | input | 1 | High when program voltage is above lockout |
| rdata | output | DW (16) | Read data: array word or status byte; zero when not read-enabled |
| rdy | output | 1 | High when no operation is actively running |

## Verification
Erase is tried on a main block and on a boot block. Two programs to the same word check the AND behaviour. The confirm address is placed at different offsets inside the block, which shows whether the map finds the block base rather than using the raw address. Bit patterns that differ per test separate a correct AND from a plain overwrite, and a wrongly targeted word from a correct one. The error paths (broken erase sequence, write protect on boot versus parameter blocks, low program voltage) each leave a distinct status code. Re-reading the target words after each error shows that the array was not touched. Nested suspend with a resume in between separates innermost-first resume from resuming the erase early.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] OP_READ_ARRAY   = 8'hFF;
    localparam logic [7:0] OP_READ_STATUS  = 8'h70;
    localparam logic [7:0] OP_CLEAR_STATUS = 8'h50;
    localparam logic [7:0] OP_ERASE_SETUP  = 8'h20;
    localparam logic [7:0] OP_CONFIRM      = 8'hD0;
    localparam logic [7:0] OP_SUSPEND      = 8'hB0;
    localparam logic [7:0] OP_PROG_SETUP   = 8'h40;
    localparam logic [7:0] OP_PROG_ALT     = 8'h10;

    typedef enum logic [1:0] {
        ARM_NONE,
        ARM_ERASE,
        ARM_PROG
    } arm_e;

    typedef struct packed {
        logic erase_err;
        logic prog_err;
        logic vpp_low;
        logic protect;
    } err_t;

    typedef struct packed {
        logic ready;
        logic erase_susp;
        logic erase_err;
        logic prog_err;
        logic vpp_low;
        logic write_susp;
        logic protect;
        logic zero;
    } status_t;

    function automatic logic is_prog_setup(input logic [7:0] op);
        return (op == OP_PROG_SETUP) || (op == OP_PROG_ALT);
    endfunction

    function automatic status_t make_status(input logic busy, input logic es,
                                            input logic ws, input err_t e);
        status_t s;
        s.ready      = ~busy;
        s.erase_susp = es;
        s.erase_err  = e.erase_err;
        s.prog_err   = e.prog_err;
        s.vpp_low    = e.vpp_low;
        s.write_susp = ws;
        s.protect    = e.protect;
        s.zero       = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
    parameter int AW = 9,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          stb,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_data
);
    logic act, act_q;

    always_comb act = ~ce_n & ~we_n;

    // The strobe pulses one cycle after the combined enable ends; the
    // latched values are those of the last cycle it was active.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= 1'b0;
            stb      <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            act_q <= act;
            stb   <= act_q & ~act;
            if (act) begin
                cap_addr <= addr;
                cap_data <= wdata;
            end
        end
    end
endmodule

// File: rtl/flash_block_map.sv
module flash_block_map #(
    parameter int AW       = 9,
    parameter int SMALL_W  = 4,
    parameter int BIG_W    = 32,
    parameter int N_BOOT   = 2,
    parameter int N_PARAM  = 6,
    parameter int N_MAIN   = 15,
    parameter bit BOOT_TOP = 1'b1
) (
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] base,
    output logic [AW-1:0] last,
    output logic          is_boot
);
    localparam int SMALL_SH = $clog2(SMALL_W);
    localparam int BIG_SH   = $clog2(BIG_W);
    localparam logic [AW-1:0] SMALL_SPAN = AW'((N_BOOT + N_PARAM) * SMALL_W);
    localparam logic [AW-1:0] MAIN_SPAN  = AW'(N_MAIN * BIG_W);
    localparam logic [AW-1:0] SMALL_LAST = AW'(SMALL_W - 1);
    localparam logic [AW-1:0] BIG_LAST   = AW'(BIG_W - 1);

    logic          in_small;
    logic [AW-1:0] small_idx;

    generate
        if (BOOT_TOP) begin : g_top
            logic [AW-1:0] off;
            always_comb begin
                in_small  = addr >= MAIN_SPAN;
                off       = addr - MAIN_SPAN;
                small_idx = off >> SMALL_SH;
                is_boot   = in_small && (small_idx >= AW'(N_PARAM));
                base      = in_small ? (MAIN_SPAN + (small_idx << SMALL_SH))
                                     : ((addr >> BIG_SH) << BIG_SH);
            end
        end else begin : g_bottom
            logic [AW-1:0] off;
            always_comb begin
                in_small  = addr < SMALL_SPAN;
                off       = addr - SMALL_SPAN;
                small_idx = addr >> SMALL_SH;
                is_boot   = in_small && (small_idx < AW'(N_BOOT));
                base      = in_small ? (small_idx << SMALL_SH)
                                     : (SMALL_SPAN + ((off >> BIG_SH) << BIG_SH));
            end
        end
    endgenerate

    always_comb last = base + (in_small ? SMALL_LAST : BIG_LAST);
endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int AW    = 9,
    parameter int DW    = 16,
    parameter int DEPTH = 512
) (
    input  logic          clk,
    input  logic          ers_en,
    input  logic [AW-1:0] ers_addr,
    input  logic          pgm_en,
    input  logic [AW-1:0] pgm_addr,
    input  logic [DW-1:0] pgm_data,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Non-volatile: no reset. Erase sets ones, programming only clears bits.
    always_ff @(posedge clk) begin
        if (ers_en)
            mem[ers_addr] <= '1;
        else if (pgm_en)
            mem[pgm_addr] <= mem[pgm_addr] & pgm_data;
    end

    always_comb rdata = mem[raddr];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int DW           = 16,
    parameter int SMALL_W      = 4,
    parameter int BIG_W        = 32,
    parameter int N_BOOT       = 2,
    parameter int N_PARAM      = 6,
    parameter int N_MAIN       = 15,
    parameter bit BOOT_TOP     = 1'b1,
    parameter int WRITE_CYCLES = 8,
    localparam int DEPTH = (N_BOOT + N_PARAM) * SMALL_W + N_MAIN * BIG_W,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wp,
    input  logic          vpp_ok,
    output logic [DW-1:0] rdata,
    output logic          rdy
);
    localparam int CW = $clog2(WRITE_CYCLES + 1);

    logic          cmd_stb;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic [7:0]    op;

    flash_bus_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .wdata(wdata),
        .stb(cmd_stb), .cap_addr(cmd_addr), .cap_data(cmd_data)
    );

    logic [AW-1:0] blk_base, blk_last;
    logic          blk_boot;

    flash_block_map #(
        .AW(AW), .SMALL_W(SMALL_W), .BIG_W(BIG_W), .N_BOOT(N_BOOT),
        .N_PARAM(N_PARAM), .N_MAIN(N_MAIN), .BOOT_TOP(BOOT_TOP)
    ) u_map (
        .addr(cmd_addr), .base(blk_base), .last(blk_last), .is_boot(blk_boot)
    );

    arm_e          arm;
    logic          rd_status;
    logic          erase_run, erase_susp;
    logic [AW-1:0] erase_ptr, erase_last;
    logic          write_run, write_susp;
    logic [CW-1:0] wcnt;
    logic [AW-1:0] w_addr;
    logic [DW-1:0] w_data;
    err_t          err;

    logic          busy, ers_en, ers_done, pgm_en;
    logic          lock_vpp, lock_boot;
    status_t       sr;
    logic [DW-1:0] arr_rdata;

    always_comb begin
        op        = cmd_data[7:0];
        busy      = (erase_run & ~erase_susp) | (write_run & ~write_susp);
        ers_en    = erase_run & ~erase_susp & ~write_run;
        ers_done  = ers_en & (erase_ptr == erase_last);
        pgm_en    = write_run & ~write_susp & (wcnt == CW'(1));
        lock_vpp  = ~vpp_ok;
        lock_boot = wp & blk_boot;
        sr        = make_status(busy, erase_susp, write_susp, err);
    end

    flash_array #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_arr (
        .clk(clk),
        .ers_en(ers_en), .ers_addr(erase_ptr),
        .pgm_en(pgm_en), .pgm_addr(w_addr), .pgm_data(w_data),
        .raddr(addr), .rdata(arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            arm        <= ARM_NONE;
            rd_status  <= 1'b0;
            erase_run  <= 1'b0;
            erase_susp <= 1'b0;
            erase_ptr  <= '0;
            erase_last <= '0;
            write_run  <= 1'b0;
            write_susp <= 1'b0;
            wcnt       <= '0;
            w_addr     <= '0;
            w_data     <= '0;
            err        <= '0;
        end else begin
            // Engine progress
            if (ers_en) begin
                if (ers_done) erase_run <= 1'b0;
                else          erase_ptr <= erase_ptr + 1'b1;
            end
            if (write_run && !write_susp) begin
                if (pgm_en) write_run <= 1'b0;
                else        wcnt      <= wcnt - 1'b1;
            end

            // Command interpreter
            if (cmd_stb) begin
                if (arm == ARM_ERASE) begin
                    arm       <= ARM_NONE;
                    rd_status <= 1'b1;
                    if (op != OP_CONFIRM) begin
                        err.erase_err <= 1'b1;
                        err.prog_err  <= 1'b1;
                    end else if (lock_vpp) begin
                        err.erase_err <= 1'b1;
                        err.vpp_low   <= 1'b1;
                    end else if (lock_boot) begin
                        err.erase_err <= 1'b1;
                        err.protect   <= 1'b1;
                    end else begin
                        erase_run  <= 1'b1;
                        erase_ptr  <= blk_base;
                        erase_last <= blk_last;
                    end
                end else if (arm == ARM_PROG) begin
                    arm       <= ARM_NONE;
                    rd_status <= 1'b1;
                    if (lock_vpp) begin
                        err.prog_err <= 1'b1;
                        err.vpp_low  <= 1'b1;
                    end else if (lock_boot) begin
                        err.prog_err <= 1'b1;
                        err.protect  <= 1'b1;
                    end else begin
                        write_run <= 1'b1;
                        wcnt      <= CW'(WRITE_CYCLES);
                        w_addr    <= cmd_addr;
                        w_data    <= cmd_data;
                    end
                end else if (busy) begin
                    if (op == OP_SUSPEND) begin
                        rd_status <= 1'b1;
                        if (write_run) begin
                            if (!pgm_en) write_susp <= 1'b1;
                        end else if (!ers_done) begin
                            erase_susp <= 1'b1;
                        end
                    end
                end else begin
                    case (op)
                        OP_READ_ARRAY:   rd_status <= 1'b0;
                        OP_READ_STATUS:  rd_status <= 1'b1;
                        OP_CLEAR_STATUS: err <= '0;
                        OP_ERASE_SETUP: begin
                            if (!erase_run && !write_run) begin
                                arm       <= ARM_ERASE;
                                rd_status <= 1'b1;
                            end
                        end
                        OP_CONFIRM: begin
                            if (write_susp) begin
                                write_susp <= 1'b0;
                                rd_status  <= 1'b1;
                            end else if (erase_susp && !write_run) begin
                                erase_susp <= 1'b0;
                                rd_status  <= 1'b1;
                            end
                        end
                        default: begin
                            if (is_prog_setup(op) && !write_run) begin
                                arm       <= ARM_PROG;
                                rd_status <= 1'b1;
                            end
                        end
                    endcase
                end
            end
        end
    end

    always_comb begin
        if (ce_n || oe_n)
            rdata = '0;
        else if (rd_status || busy)
            rdata = {{(DW-8){1'b0}}, sr};
        else
            rdata = arr_rdata;
    end

    always_comb rdy = ~busy;

endmodule

module flash_cmd_ctrl_chk #(
    parameter int AW = 9,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          rdy,
    input logic          rd_status,
    input logic          erase_run,
    input logic          erase_susp,
    input logic          write_run,
    input logic          write_susp,
    input logic [AW-1:0] erase_ptr,
    input logic [CW-1:0] wcnt,
    input logic          prot_flag
);
    a_r1_reset_array_ready: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rdy && !rd_status));

    a_r10_erase_frozen: assert property (@(posedge clk) disable iff (rst)
        (erase_susp && $past(erase_susp)) |-> $stable(erase_ptr));

    a_r10_susp_needs_erase: assert property (@(posedge clk) disable iff (rst)
        erase_susp |-> erase_run);

    a_r10_nested_only_when_suspended: assert property (@(posedge clk) disable iff (rst)
        (write_run && erase_run) |-> erase_susp);

    a_r11_write_frozen: assert property (@(posedge clk) disable iff (rst)
        (write_susp && $past(write_susp)) |-> $stable(wcnt));

    a_r11_susp_needs_write: assert property (@(posedge clk) disable iff (rst)
        write_susp |-> write_run);

    a_r8_locked_starts_nothing: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_flag) |-> (!$rose(write_run) && !$rose(erase_run)));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .rdy(rdy), .rd_status(rd_status),
    .erase_run(erase_run), .erase_susp(erase_susp),
    .write_run(write_run), .write_susp(write_susp),
    .erase_ptr(erase_ptr), .wcnt(wcnt), .prot_flag(err.protect)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [8:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wp = 1'b0, vpp_ok = 1'b1;
    logic [15:0] rdata;
    logic        rdy;

    int vectors = 0;
    int fails   = 0;

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    flash_cmd_ctrl dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .wp(wp), .vpp_ok(vpp_ok),
        .rdata(rdata), .rdy(rdy)
    );

    // Monitor: compares every enabled read against the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!ce_n && !oe_n && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                vectors++;
                if (rdata !== e.val) begin
                    fails++;
                    $display("FAIL %s: read %h expected %h", e.tag, rdata, e.val);
                end
            end
        end
    end

    // Bus write; address and data are scrambled as the strobe ends (R12).
    task automatic bus_wr(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; addr = ~a; wdata = ~d;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_exp(input logic [8:0] a, input logic [15:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic chk_rdy(input logic v, input string tag);
        vectors++;
        if (rdy !== v) begin
            fails++;
            $display("FAIL %s: rdy %b expected %b", tag, rdy, v);
        end
    endtask

    task automatic wait_ready(input string tag);
        for (int i = 0; i < 400; i++) begin
            if (rdy) break;
            @(negedge clk);
        end
        chk_rdy(1'b1, tag);
    endtask

    task automatic erase_at(input logic [8:0] a);
        bus_wr(a, 16'h0020);
        bus_wr(a, 16'h00D0);
    endtask

    task automatic prog(input logic [8:0] a, input logic [15:0] d);
        bus_wr(a, 16'h0040);
        bus_wr(a, d);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk_rdy(1'b1, "R1 rdy after reset");
        bus_wr(0, 16'h0070);
        rd_exp(0, 16'h0080, "R1 clean status");

        // R2 / R14 / R6: erase block 0 with confirm address inside block
        erase_at(9'd5);
        chk_rdy(1'b0, "R6 busy during erase");
        rd_exp(3, 16'h0000, "R14 read while busy gives status");
        bus_wr(0, 16'h00FF);
        wait_ready("R2 erase completes");
        rd_exp(10, 16'h0080, "R14 FFh ignored while busy");
        bus_wr(0, 16'h00FF);
        rd_exp(0, 16'hFFFF, "R2 block start erased");
        rd_exp(31, 16'hFFFF, "R2 block end erased");

        // R3 / R1: program, reset keeps memory and returns to array mode
        prog(9'd7, 16'hA5A5);
        chk_rdy(1'b0, "R6 busy during program");
        wait_ready("R3 program completes");
        rd_exp(200, 16'h0080, "R4 status mode after program");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_exp(7, 16'hA5A5, "R1 array mode after reset");
        bus_wr(7, 16'h0010);
        bus_wr(7, 16'h0FF0);
        wait_ready("R3 alt setup completes");
        bus_wr(0, 16'h00FF);
        rd_exp(7, 16'h05A0, "R3 program ANDs old word");

        // R2: neighbouring block untouched
        prog(9'd31, 16'h1234);
        wait_ready("R3 program 31");
        erase_at(9'd63);
        wait_ready("R2 erase block 1");
        bus_wr(0, 16'h00FF);
        rd_exp(32, 16'hFFFF, "R2 block 1 first word");
        rd_exp(31, 16'h1234, "R2 neighbour kept");
        rd_exp(31, 16'h1234, "R12 scrambled addr after strobe ignored");

        // R7: broken erase sequence
        bus_wr(0, 16'h0020);
        bus_wr(0, 16'h00FF);
        rd_exp(0, 16'h00B0, "R7 sequence error bits 5 and 4");
        bus_wr(0, 16'h00FF);
        rd_exp(7, 16'h05A0, "R7 nothing erased");
        bus_wr(0, 16'h0050);
        bus_wr(0, 16'h0070);
        rd_exp(0, 16'h0080, "R5 clear status");

        // R13 / R8: boot and parameter blocks at the top of the map
        erase_at(9'd505);
        wait_ready("R13 boot erase unlocked");
        prog(9'd505, 16'h00AA);
        wait_ready("R13 boot program");
        wp = 1'b1;
        erase_at(9'd501);
        wait_ready("R8 param erase with wp");
        rd_exp(0, 16'h0080, "R8 param block not locked");
        prog(9'd505, 16'h0000);
        rd_exp(0, 16'h0092, "R8 boot program refused");
        bus_wr(0, 16'h0050);
        erase_at(9'd506);
        rd_exp(0, 16'h00A2, "R8 boot erase refused");
        bus_wr(0, 16'h0050);
        bus_wr(0, 16'h00FF);
        rd_exp(505, 16'h00AA, "R8 boot word unchanged");
        rd_exp(500, 16'hFFFF, "R13 param block 500 erased");
        wp = 1'b0;

        // R9: program voltage low
        vpp_ok = 1'b0;
        erase_at(9'd10);
        rd_exp(0, 16'h00A8, "R9 erase locked");
        bus_wr(0, 16'h0050);
        prog(9'd7, 16'h0000);
        rd_exp(0, 16'h0098, "R9 program locked");
        bus_wr(0, 16'h0050);
        bus_wr(0, 16'h00FF);
        rd_exp(7, 16'h05A0, "R9 array unchanged");
        vpp_ok = 1'b1;

        // R10 / R11: nested suspend
        erase_at(9'd70);
        bus_wr(0, 16'h00B0);
        rd_exp(0, 16'h00C0, "R10 erase suspended");
        chk_rdy(1'b1, "R6 ready while suspended");
        bus_wr(0, 16'h00FF);
        rd_exp(31, 16'h1234, "R10 array read in suspend");
        prog(9'd31, 16'h0204);
        wait_ready("R10 program in erase suspend");
        rd_exp(0, 16'h00C0, "R10 erase still suspended");
        prog(9'd30, 16'h00F0);
        bus_wr(0, 16'h00B0);
        rd_exp(0, 16'h00C4, "R11 write suspended");
        bus_wr(0, 16'h0040);
        bus_wr(0, 16'h0020);
        rd_exp(0, 16'h00C4, "R11 setups ignored in write suspend");
        bus_wr(0, 16'h00D0);
        chk_rdy(1'b0, "R11 program resumed first");
        wait_ready("R11 resumed program done");
        rd_exp(0, 16'h00C0, "R11 erase still suspended after write");
        bus_wr(0, 16'h00D0);
        chk_rdy(1'b0, "R10 erase resumed");
        wait_ready("R10 erase done");
        rd_exp(0, 16'h0080, "R10 clean status after resume");
        bus_wr(0, 16'h00FF);
        rd_exp(64, 16'hFFFF, "R10 block 2 start erased");
        rd_exp(95, 16'hFFFF, "R10 block 2 end erased");
        rd_exp(31, 16'h0204, "R10 nested program result");
        rd_exp(30, 16'h00F0, "R11 suspended program result");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule